// File: doc/BRIEF.md
# Block-move DMA requester

This engine shares a system bus with a primary master and moves a block of words from a device receive buffer into memory. Software loads a start address and a block length, then writes a control word that picks the transfer mode and starts the move. The engine raises a bus request, waits for the grant, writes words into memory through a synchronous write port, and then hands the bus back. Each word comes from a show-ahead FIFO read port: the head word is valid whenever the FIFO is not empty, and a pop consumes it.

There are two modes. In burst mode the engine keeps the bus for the whole block, and it stalls in place while the FIFO runs dry. In cycle-steal mode it asks for the bus only when the primary master leaves the bus free. It then writes one word, drops the request, and rests for at least one cycle before it asks again. When the final word of the block has been written, a sticky interrupt is raised and stays up until software acknowledges it.

Top module: `blkmove_dma`

## Requirements
- R1: The engine drives `mem_we` and `fifo_pop` only in cycles where it holds both `bus_req` and `bus_gnt`, which means after a grant has answered its request.
- R2: In burst mode (control bit 1 = 0) the whole block is written during one continuous tenure, so the engine accepts exactly one grant per block.
- R3: In cycle-steal mode (control bit 1 = 1) each tenure carries exactly one word. A new request rises only in a cycle where `bus_busy` is low.
- R4: Word k of a block (k = 0, 1, ...) is written to the programmed start address plus k, modulo 2^ADDR_W. Its data is the k-th word popped from the FIFO.
- R5: The length register holds the word count minus one, so the value 0 moves 1 word and the value 255 moves 256 words.
- R6: `irq` rises in the cycle after the final word is written. It stays high until a control write with bit 2 set, and it is low from the cycle after that write.
- R7: A control write with bit 0 (start) set is ignored while a block is in progress. The ongoing block keeps its mode, its addresses and its length, and no further block follows it.
- R8: In burst mode with the FIFO empty, the engine keeps `bus_req` high and writes nothing until data arrives.
- R9: The request falls in the cycle after a tenure's last write, and it stays low in that cycle.
- R10: After reset, `bus_req`, `mem_we`, `fifo_pop` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load strobe for the start address |
| base_in | input | ADDR_W | Start address value |
| len_we | input | 1 | Load strobe for the length register |
| len_in | input | CNT_W | Word count minus one |
| ctl_we | input | 1 | Control write strobe |
| ctl_in | input | 3 | bit0 start, bit1 cycle-steal mode, bit2 interrupt acknowledge |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_busy | input | 1 | Primary master is using the bus |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| fifo_empty | input | 1 | Device FIFO holds no word |
| fifo_rdata | input | DATA_W | Head word of the device FIFO |
| fifo_pop | output | 1 | Consume the FIFO head word |
| irq | output | 1 | Block-complete interrupt |

## Verification
A table of blocks runs single-word, short, wrapping-address, maximum-length and cycle-steal transfers. Some are run with a periodic busy pattern on the bus and some without. Comparing grant counts between modes shows whether the engine holds one tenure or takes one grant per word. The busy pattern shows whether requests in cycle-steal mode respect bus activity, and it shows that burst mode ignores it. In a directed run the FIFO is starved partway through a burst, which tells a stall that holds the bus apart from an early release. In another, a second start and a new address are written in the middle of a block, which shows whether the running block is disturbed.

// File: rtl/blkmove_pkg.sv
`timescale 1ns/1ps
package blkmove_pkg;
  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_ASK  = 2'd1,
    MV_MOVE = 2'd2,
    MV_REST = 2'd3
  } mv_state_e;

  localparam int CTL_W     = 3;
  localparam int CTL_GO    = 0;
  localparam int CTL_STEAL = 1;
  localparam int CTL_ACK   = 2;
endpackage

// File: rtl/blkmove_rst_sync.sv
`timescale 1ns/1ps
module blkmove_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/blkmove_cfg.sv
`timescale 1ns/1ps
module blkmove_cfg
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_in,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic              active,
  input  logic              done_set,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  len_q,
  output logic              go,
  output logic              go_steal,
  output logic              irq
);
  logic ack;
  logic irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_in;
  end

  // start is honoured only when no block is in flight
  assign go       = ctl_we & ctl_in[CTL_GO] & ~active;
  assign go_steal = ctl_in[CTL_STEAL];
  assign ack      = ctl_we & ctl_in[CTL_ACK];

  always_comb begin
    irq_d = irq;
    if (ack)      irq_d = 1'b0;
    if (done_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
endmodule

// File: rtl/blkmove_walk.sv
`timescale 1ns/1ps
module blkmove_walk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  output logic [ADDR_W-1:0] addr_q,
  output logic              last_word
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = 1;

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= base;
      rem_q  <= len;
    end else if (step) begin
      addr_q <= addr_q + ADDR_ONE;
      rem_q  <= rem_q - CNT_ONE;
    end
  end

  // rem_q counts words still to go after the current one
  assign last_word = (rem_q == '0);

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == $past(addr_q) + ADDR_ONE));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word) |=> !step);
endmodule

// File: rtl/blkmove_ctrl.sv
`timescale 1ns/1ps
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_steal,
  input  logic bus_gnt,
  input  logic bus_busy,
  input  logic fifo_empty,
  input  logic last_word,
  output logic bus_req,
  output logic step,
  output logic load,
  output logic active
);
  mv_state_e st_q, st_d;
  logic      steal_q;
  logic      ask_ok;

  // cycle-steal asks only while the bus is free and a word is waiting
  assign ask_ok  = ~steal_q | (~bus_busy & ~fifo_empty);
  assign bus_req = ((st_q == MV_ASK) & ask_ok) | (st_q == MV_MOVE);
  assign step    = (st_q == MV_MOVE) & ~fifo_empty;
  assign load    = go;
  assign active  = (st_q != MV_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MV_IDLE: if (go) st_d = MV_ASK;
      MV_ASK:  if (bus_req && bus_gnt) st_d = MV_MOVE;
      MV_MOVE: begin
        if (step) begin
          if (last_word)    st_d = MV_IDLE;
          else if (steal_q) st_d = MV_REST;
        end
      end
      MV_REST: st_d = MV_ASK;
      default: st_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MV_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    steal_q <= 1'b0;
    else if (load) steal_q <= go_steal;
  end

  assert_burst_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!steal_q && bus_req && bus_gnt && !(step && last_word)) |=> bus_req);

  assert_one_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_q && step) |=> !bus_req);

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (steal_q == $past(steal_q)));

  assert_stall_keeps_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MV_MOVE) && fifo_empty) |=> bus_req);

  assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word) |=> !bus_req);
endmodule

// File: rtl/blkmove_dma.sv
`timescale 1ns/1ps
module blkmove_dma
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_in,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_in,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              irq
);
  logic              rst_s_n;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  len_q;
  logic              go, go_steal, active, load, step, last_word;

  blkmove_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  blkmove_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .base_we  (base_we),
    .base_in  (base_in),
    .len_we   (len_we),
    .len_in   (len_in),
    .ctl_we   (ctl_we),
    .ctl_in   (ctl_in),
    .active   (active),
    .done_set (step & last_word),
    .base_q   (base_q),
    .len_q    (len_q),
    .go       (go),
    .go_steal (go_steal),
    .irq      (irq)
  );

  blkmove_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .go         (go),
    .go_steal   (go_steal),
    .bus_gnt    (bus_gnt),
    .bus_busy   (bus_busy),
    .fifo_empty (fifo_empty),
    .last_word  (last_word),
    .bus_req    (bus_req),
    .step       (step),
    .load       (load),
    .active     (active)
  );

  blkmove_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (load),
    .step      (step),
    .base      (base_q),
    .len       (len_q),
    .addr_q    (mem_addr),
    .last_word (last_word)
  );

  assign mem_we    = step;
  assign fifo_pop  = step;
  assign mem_wdata = fifo_rdata;

  assert_write_owned_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> (bus_req && bus_gnt));

  assert_write_has_data_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> !fifo_empty);
endmodule

// File: tb/test_blkmove_dma.sv
`timescale 1ns/1ps
module test_blkmove_dma;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] DBASE = 32'hC0DE_0000;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [CNT_W-1:0]  n;
    logic              m;
    logic              b;
  } vec_t;

  // start address, length-1, steal mode, busy pattern on
  localparam vec_t VECS [6] = '{
    '{16'h0100, 8'd0,   1'b0, 1'b0},
    '{16'h2000, 8'd15,  1'b0, 1'b1},
    '{16'hFFFE, 8'd3,   1'b0, 1'b0},
    '{16'h0040, 8'd6,   1'b1, 1'b1},
    '{16'h0300, 8'd255, 1'b0, 1'b0},
    '{16'h1234, 8'd2,   1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic base_we, len_we, ctl_we;
  logic [ADDR_W-1:0] base_in;
  logic [CNT_W-1:0]  len_in;
  logic [2:0]        ctl_in;
  logic bus_req, bus_gnt, bus_busy, mem_we, fifo_empty, fifo_pop, irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, fifo_rdata;

  int nchk = 0;
  int nfail = 0;
  int level, pops, cyc;
  logic refill_en, busy_en, steal_run, mon_clr;
  int total, wr_cnt, grants;
  logic prev_own, prev_req, prev_we;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;

  always #2 clk = ~clk;  // 4 ns period

  blkmove_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_blkmove_dma (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_in(base_in),
    .len_we(len_we), .len_in(len_in),
    .ctl_we(ctl_we), .ctl_in(ctl_in),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_busy(bus_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .irq(irq)
  );

  // arbiter grants one cycle after the request; FIFO and busy models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 0; pops <= 0; cyc <= 0; bus_gnt <= 1'b0; bus_busy <= 1'b0;
    end else begin
      level    <= level - (fifo_pop ? 1 : 0) + ((refill_en && level < 4) ? 1 : 0);
      pops     <= pops + (fifo_pop ? 1 : 0);
      cyc      <= cyc + 1;
      bus_gnt  <= bus_req;
      bus_busy <= busy_en && (cyc % 3 == 0);
    end
  end
  assign fifo_empty = (level == 0);
  assign fifo_rdata = DBASE + pops;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_clr) begin
      wr_cnt = 0; grants = 0; prev_own = 1'b0; prev_req = 1'b0; prev_we = 1'b0;
    end else begin
      if (prev_we && (steal_run || wr_cnt == total))
        chk(!bus_req, "R9 request low after tenure", bus_req, 0);
      if (bus_req && bus_gnt && !prev_own) grants++;
      if (steal_run && bus_req && !prev_req)
        chk(!bus_busy, "R3 request raised while busy", bus_busy, 0);
      if (mem_we) begin
        chk(bus_req && bus_gnt, "R1 write without ownership", {bus_req, bus_gnt}, 2'b11);
        chk(mem_addr == exp_addr, "R4 address", mem_addr, exp_addr);
        chk(mem_wdata == exp_data, "R4 data", mem_wdata, exp_data);
        exp_addr++; exp_data++; wr_cnt++;
      end
      prev_own = bus_req && bus_gnt;
      prev_req = bus_req;
      prev_we  = mem_we;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n, input logic m, input logic b);
    base_we = 1'b1; base_in = a; len_we = 1'b1; len_in = n;
    steal_run = m; busy_en = b; total = int'(n) + 1;
    exp_addr = a; exp_data = DBASE + pops; mon_clr = 1'b1;
    step();
    base_we = 1'b0; len_we = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic kick(input logic m);
    ctl_we = 1'b1; ctl_in = {1'b0, m, 1'b1};
    step();
    ctl_we = 1'b0; ctl_in = 3'b000;
  endtask

  task automatic wait_irq();
    for (int t = 0; t < 4000 && !irq; t++) step();
    chk(irq, "R6 interrupt after block", irq, 1);
  endtask

  task automatic ack_irq();
    repeat (5) step();
    chk(irq, "R6 interrupt held", irq, 1);
    ctl_we = 1'b1; ctl_in = 3'b100;
    step();
    ctl_we = 1'b0; ctl_in = 3'b000;
    step();
    chk(!irq, "R6 interrupt cleared", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; base_we = 1'b0; len_we = 1'b0; ctl_we = 1'b0;
    base_in = '0; len_in = '0; ctl_in = 3'b000;
    refill_en = 1'b1; busy_en = 1'b0; steal_run = 1'b0; mon_clr = 1'b1;
    total = 0; exp_addr = '0; exp_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    mon_clr = 1'b0;
    // R10 reset state
    chk(!bus_req, "R10 bus_req after reset", bus_req, 0);
    chk(!mem_we, "R10 mem_we after reset", mem_we, 0);
    chk(!fifo_pop, "R10 fifo_pop after reset", fifo_pop, 0);
    chk(!irq, "R10 irq after reset", irq, 0);

    for (int v = 0; v < 6; v++) begin
      prog(VECS[v].a, VECS[v].n, VECS[v].m, VECS[v].b);
      kick(VECS[v].m);
      wait_irq();
      chk(wr_cnt == total, "R5 word count", wr_cnt, total);
      if (VECS[v].m)
        chk(grants == total, "R3 one grant per word", grants, total);
      else
        chk(grants == 1, "R2 single tenure", grants, 1);
      ack_irq();
    end

    // R8: starve the FIFO part way through a burst
    refill_en = 1'b1;
    repeat (6) step();
    refill_en = 1'b0;
    prog(16'h0900, 8'd9, 1'b0, 1'b0);
    kick(1'b0);
    repeat (20) step();
    chk(bus_req, "R8 request held while empty", bus_req, 1);
    chk(wr_cnt == 4, "R8 writes stop when empty", wr_cnt, 4);
    chk(!mem_we, "R8 no write while empty", mem_we, 0);
    refill_en = 1'b1;
    wait_irq();
    chk(wr_cnt == 10, "R8 block completes", wr_cnt, 10);
    chk(grants == 1, "R8 bus kept through stall", grants, 1);
    ack_irq();

    // R7: start and new address written mid-block
    prog(16'h0500, 8'd19, 1'b0, 1'b0);
    kick(1'b0);
    repeat (4) step();
    base_we = 1'b1; base_in = 16'h7777;
    ctl_we = 1'b1; ctl_in = 3'b011;
    step();
    base_we = 1'b0; ctl_we = 1'b0; ctl_in = 3'b000;
    wait_irq();
    chk(wr_cnt == 20, "R7 length unchanged", wr_cnt, 20);
    chk(grants == 1, "R7 mode unchanged", grants, 1);
    ack_irq();
    repeat (10) step();
    chk(!bus_req, "R7 no second block", bus_req, 0);
    chk(wr_cnt == 20, "R7 no extra writes", wr_cnt, 20);

    finish_up();
  end
endmodule